// File: doc/BRIEF.md
# I2C Bus Master Engine with Control-Bit Sequencing

This block is a byte-level I2C bus master programmed through a small synchronous register bus. Bus conditions follow the level of bits in the control register instead of command strobes. Setting the master bit places a START on the bus. Clearing it places a STOP. Writing the self-clearing repeat bit places a repeated START. Each write to the data register while the engine holds the bus moves one byte plus its acknowledge slot. The direction bit decides whether the written byte is shifted out or a byte is shifted in.

SDA and SCL are open-drain. The block only ever pulls a line low or releases it. A bus monitor synchronises both lines, tracks START and STOP from any master, and reports the bus as busy. The engine checks every bit it releases and gives up the bus as soon as it sees another driver. A byte-complete flag and an arbitration-lost flag feed one interrupt line, which the interrupt-enable bit gates.

Register map, as 2-bit address: 0 control, 1 status, 2 data (write: byte to send or receive trigger; read: last received byte), 3 clock divider.

Top module: `i2c_ctrl_eng`

## Requirements
- R1: After reset the control and status registers read 0x00, the data register reads 0x00, and both lines are released (scl_oe_o = sda_oe_o = 0).
- R2: Control bits are bit 7 enable, bit 6 interrupt enable, bit 5 master, bit 4 transmit, bit 3 acknowledge disable, bit 2 repeat. Bits 2, 1 and 0 always read 0.
- R3: While the enable bit is 0, both lines stay released and a write of the master bit is dropped: the master bit reads 0 and no START appears.
- R4: A 0→1 change of the master bit while the bus is idle drives SDA low while SCL is high, then holds SCL low. Status bit 6 (busy) reads 1 once that START is on the bus.
- R5: In transmit mode, a data write while holding the bus sends 8 bits MSB first on 9 SCL pulses. The level sampled in the 9th slot is stored in status bit 0 (0 = ACK, 1 = NACK).
- R6: In receive mode, a data write while holding the bus shifts in 8 bits MSB first, and the byte is then readable at address 2. In the 9th slot SDA is pulled low when acknowledge disable is 0 and released when it is 1.
- R7: Status bit 7 (byte done) sets at the falling SCL edge that ends the 9th pulse, with SCL then held low. Writing 1 to status bit 7 clears it.
- R8: A 1→0 change of the master bit while holding the bus releases SCL, then releases SDA while SCL is high (STOP), and busy then reads 0.
- R9: Writing the repeat bit while master and holding the bus produces a new START without any STOP in between.
- R10: Writing the repeat bit while not master sets status bit 4 (arbitration lost) and puts nothing on the bus. Writing 1 to status bit 4 clears it.
- R11: If SDA reads low in a bit the engine released, the engine sets arbitration lost, releases both lines, clears the master bit, and issues no STOP.
- R12: irq_o is 1 exactly when interrupt enable is 1 and byte done or arbitration lost is set.
- R13: While a byte is in flight, the SCL period is 4 × (divider + 1) clock cycles. The divider resets to 4 and must be at least 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 2 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Interrupt request |
| scl_i | input | 1 | SCL line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
A wrong phase or bit counter shows up at the ports within one bit time. The byte the bus model captures is wrong, or the SCL pulse count per byte is off, so the byte-done flag rises at the wrong moment. A control-bit decode fault produces a START or STOP the bus model does not expect, or misses one, and the flag or busy status disagrees within a few quarter-bit ticks. Arbitration and repeat-bit faults leave the master bit or the arbitration-lost flag in the wrong state on the next register read.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
  localparam int unsigned DATA_W = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_DIV  = 2'd3;

  // control bit positions
  localparam int unsigned C_EN   = 7;
  localparam int unsigned C_IE   = 6;
  localparam int unsigned C_MST  = 5;
  localparam int unsigned C_TX   = 4;
  localparam int unsigned C_NACK = 3;
  localparam int unsigned C_RPT  = 2;

  // status bit positions
  localparam int unsigned S_DONE = 7;
  localparam int unsigned S_BUSY = 6;
  localparam int unsigned S_MST  = 5;
  localparam int unsigned S_AL   = 4;
  localparam int unsigned S_RACK = 0;

  typedef enum logic [2:0] {
    E_IDLE   = 3'd0,
    E_START  = 3'd1,
    E_HOLD   = 3'd2,
    E_BIT    = 3'd3,
    E_RSTART = 3'd4,
    E_STOP   = 3'd5
  } eng_state_e;
endpackage

// File: rtl/i2c_eng_tick.sv
module i2c_eng_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == div_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_eng_busmon.sv
module i2c_eng_busmon #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic busy_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_prev, sda_prev;
  logic start_det, stop_det;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scl_sync[i] <= 1'b1;
        sda_sync[i] <= 1'b1;
      end else if (i == 0) begin
        scl_sync[i] <= scl_i;
        sda_sync[i] <= sda_i;
      end else begin
        scl_sync[i] <= scl_sync[(i == 0) ? 0 : i-1];
        sda_sync[i] <= sda_sync[(i == 0) ? 0 : i-1];
      end
    end
  end

  assign scl_s_o = scl_sync[SYNC_STAGES-1];
  assign sda_s_o = sda_sync[SYNC_STAGES-1];

  assign start_det = scl_prev & scl_s_o & sda_prev & ~sda_s_o;
  assign stop_det  = scl_prev & scl_s_o & ~sda_prev & sda_s_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
      busy_o   <= 1'b0;
    end else begin
      scl_prev <= scl_s_o;
      sda_prev <= sda_s_o;
      if (start_det)     busy_o <= 1'b1;
      else if (stop_det) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_eng_master.sv
module i2c_eng_master
  import i2c_eng_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              mst_i,
  input  logic              rs_req_i,
  input  logic              xfer_req_i,
  input  logic              tx_mode_i,
  input  logic              ack_dis_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              bus_busy_i,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              hold_o,
  output logic              tick_clr_o,
  output logic              done_o,
  output logic              arb_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_ack_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] ACK_IDX = CNT_W'(DATA_W);

  eng_state_e        state_q;
  logic [1:0]        ph_q;
  logic [CNT_W-1:0]  bidx_q;
  logic [DATA_W-1:0] tx_sh_q;
  logic              dir_q;
  logic              drv_low, own_bit;

  // level for the current bit slot and whether the engine owns that slot
  always_comb begin
    drv_low = 1'b0;
    own_bit = 1'b0;
    if (bidx_q != ACK_IDX) begin
      if (dir_q) begin
        drv_low = ~tx_sh_q[DATA_W-1];
        own_bit = 1'b1;
      end
    end else if (!dir_q) begin
      drv_low = ~ack_dis_i;
      own_bit = 1'b1;
    end
  end

  assign hold_o     = (state_q == E_HOLD);
  assign tick_clr_o = (state_q == E_IDLE) || (state_q == E_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= E_IDLE;
      ph_q      <= '0;
      bidx_q    <= '0;
      tx_sh_q   <= '0;
      dir_q     <= 1'b0;
      scl_oe_o  <= 1'b0;
      sda_oe_o  <= 1'b0;
      done_o    <= 1'b0;
      arb_o     <= 1'b0;
      rx_byte_o <= '0;
      rx_ack_o  <= 1'b0;
    end else if (!en_i) begin
      state_q  <= E_IDLE;
      ph_q     <= '0;
      scl_oe_o <= 1'b0;
      sda_oe_o <= 1'b0;
      done_o   <= 1'b0;
      arb_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      arb_o  <= 1'b0;
      unique case (state_q)
        E_IDLE: begin
          scl_oe_o <= 1'b0;
          sda_oe_o <= 1'b0;
          ph_q     <= '0;
          if (mst_i) begin
            if (bus_busy_i) arb_o   <= 1'b1;
            else            state_q <= E_START;
          end
        end
        E_START: if (tick_i) begin
          unique case (ph_q)
            2'd0:    begin sda_oe_o <= 1'b1; ph_q <= 2'd1; end
            2'd1:    ph_q <= 2'd2;
            default: begin scl_oe_o <= 1'b1; ph_q <= '0; state_q <= E_HOLD; end
          endcase
        end
        E_HOLD: begin
          ph_q <= '0;
          if (!mst_i) state_q <= E_STOP;
          else if (rs_req_i) state_q <= E_RSTART;
          else if (xfer_req_i) begin
            state_q <= E_BIT;
            bidx_q  <= '0;
            tx_sh_q <= tx_byte_i;
            dir_q   <= tx_mode_i;
          end
        end
        E_BIT: if (tick_i) begin
          unique case (ph_q)
            2'd0: begin sda_oe_o <= drv_low; ph_q <= 2'd1; end
            2'd1: begin scl_oe_o <= 1'b0;    ph_q <= 2'd2; end
            2'd2: if (scl_s_i) begin
              if (own_bit && !drv_low && !sda_s_i) begin
                scl_oe_o <= 1'b0;
                sda_oe_o <= 1'b0;
                arb_o    <= 1'b1;
                state_q  <= E_IDLE;
                ph_q     <= '0;
              end else begin
                ph_q <= 2'd3;
                if (bidx_q != ACK_IDX && !dir_q)
                  rx_byte_o <= {rx_byte_o[DATA_W-2:0], sda_s_i};
                if (bidx_q == ACK_IDX && dir_q)
                  rx_ack_o <= sda_s_i;
              end
            end
            default: begin
              scl_oe_o <= 1'b1;
              ph_q     <= '0;
              tx_sh_q  <= {tx_sh_q[DATA_W-2:0], 1'b0};
              if (bidx_q == ACK_IDX) begin
                state_q <= E_HOLD;
                done_o  <= 1'b1;
              end else begin
                bidx_q <= bidx_q + 1'b1;
              end
            end
          endcase
        end
        E_RSTART: if (tick_i) begin
          unique case (ph_q)
            2'd0: begin sda_oe_o <= 1'b0; ph_q <= 2'd1; end
            2'd1: begin scl_oe_o <= 1'b0; ph_q <= 2'd2; end
            2'd2: if (scl_s_i) begin sda_oe_o <= 1'b1; ph_q <= 2'd3; end
            default: begin scl_oe_o <= 1'b1; ph_q <= '0; state_q <= E_HOLD; end
          endcase
        end
        E_STOP: if (tick_i) begin
          unique case (ph_q)
            2'd0: begin sda_oe_o <= 1'b1; ph_q <= 2'd1; end
            2'd1: begin scl_oe_o <= 1'b0; ph_q <= 2'd2; end
            default: if (scl_s_i) begin
              sda_oe_o <= 1'b0;
              ph_q     <= '0;
              state_q  <= E_IDLE;
            end
          endcase
        end
        default: state_q <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_ctrl_eng.sv
module i2c_ctrl_eng
  import i2c_eng_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned DIV_RST     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  input  logic              scl_i,
  output logic              scl_oe_o,
  input  logic              sda_i,
  output logic              sda_oe_o
);
  logic [DATA_W-1:0] ctrl_q, tx_q, rx_byte;
  logic [DIV_W-1:0]  div_q;
  logic              done_q, al_q, rs_q, xfer_q;
  logic              tick, tick_clr, scl_s, sda_s, busy;
  logic              eng_hold, eng_done, eng_arb, rx_ack;

  i2c_eng_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (tick_clr),
    .div_i (div_q), .tick_o (tick)
  );

  i2c_eng_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk_i (clk_i), .rst_ni (rst_ni), .scl_i (scl_i), .sda_i (sda_i),
    .scl_s_o (scl_s), .sda_s_o (sda_s), .busy_o (busy)
  );

  i2c_eng_master u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl_q[C_EN]),
    .tick_i     (tick),
    .mst_i      (ctrl_q[C_MST]),
    .rs_req_i   (rs_q),
    .xfer_req_i (xfer_q),
    .tx_mode_i  (ctrl_q[C_TX]),
    .ack_dis_i  (ctrl_q[C_NACK]),
    .tx_byte_i  (tx_q),
    .bus_busy_i (busy),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o),
    .hold_o     (eng_hold),
    .tick_clr_o (tick_clr),
    .done_o     (eng_done),
    .arb_o      (eng_arb),
    .rx_byte_o  (rx_byte),
    .rx_ack_o   (rx_ack)
  );

  logic wr_mst;
  assign wr_mst = reg_wdata_i[C_MST] & reg_wdata_i[C_EN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      tx_q   <= '0;
      div_q  <= DIV_W'(DIV_RST);
      done_q <= 1'b0;
      al_q   <= 1'b0;
      rs_q   <= 1'b0;
      xfer_q <= 1'b0;
    end else begin
      rs_q   <= 1'b0;
      xfer_q <= 1'b0;
      if (reg_we_i) begin
        unique case (reg_addr_i)
          ADDR_CTRL: begin
            ctrl_q <= {reg_wdata_i[C_EN], reg_wdata_i[C_IE], wr_mst,
                       reg_wdata_i[C_TX], reg_wdata_i[C_NACK], 3'b000};
            if (reg_wdata_i[C_RPT]) begin
              // repeat accepted only as current master at a byte boundary
              if (wr_mst && ctrl_q[C_MST] && eng_hold) rs_q <= 1'b1;
              else                                     al_q <= 1'b1;
            end
          end
          ADDR_STAT: begin
            if (reg_wdata_i[S_DONE]) done_q <= 1'b0;
            if (reg_wdata_i[S_AL])   al_q   <= 1'b0;
          end
          ADDR_DATA: begin
            tx_q <= reg_wdata_i;
            if (eng_hold && ctrl_q[C_MST] && ctrl_q[C_EN]) xfer_q <= 1'b1;
          end
          default: div_q <= reg_wdata_i[DIV_W-1:0];
        endcase
      end
      if (eng_done) done_q <= 1'b1;
      if (eng_arb) begin
        al_q          <= 1'b1;
        ctrl_q[C_MST] <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o = ctrl_q;
      ADDR_STAT: reg_rdata_o = {done_q, busy, ctrl_q[C_MST], al_q, 3'b000, rx_ack};
      ADDR_DATA: reg_rdata_o = rx_byte;
      default:   reg_rdata_o = DATA_W'(div_q);
    endcase
  end

  assign irq_o = ctrl_q[C_IE] & (done_q | al_q);
endmodule

// File: rtl/i2c_ctrl_eng_chk.sv
module i2c_ctrl_eng_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       ie_i,
  input logic       mst_i,
  input logic       done_i,
  input logic       eng_done_i,
  input logic       eng_arb_i,
  input logic [1:0] reg_addr_i,
  input logic [7:0] reg_rdata_i,
  input logic       irq_i,
  input logic       scl_oe_i,
  input logic       sda_oe_i
);
  // R3
  disabled_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!scl_oe_i && !sda_oe_i));

  // R2
  ctrl_low_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd0) |-> (reg_rdata_i[2:0] == 3'b000));

  // R11
  arb_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_arb_i |-> (!scl_oe_i && !sda_oe_i));

  // R11
  arb_mst_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_arb_i |=> !mst_i);

  // R7
  done_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done_i |-> scl_oe_i);

  // R12
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> ie_i);

  // R12
  irq_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_i && done_i) |-> irq_i);
endmodule

bind i2c_ctrl_eng i2c_ctrl_eng_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (ctrl_q[7]),
  .ie_i        (ctrl_q[6]),
  .mst_i       (ctrl_q[5]),
  .done_i      (done_q),
  .eng_done_i  (eng_done),
  .eng_arb_i   (eng_arb),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_i (reg_rdata_o),
  .irq_i       (irq_o),
  .scl_oe_i    (scl_oe_o),
  .sda_oe_i    (sda_oe_o)
);

// File: tb/tb_i2c_ctrl_eng.sv
module tb_i2c_ctrl_eng;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, scl_oe, sda_oe;
  logic       scl_bus, sda_bus, slv_low;

  int n_tests = 0, n_fail = 0, cyc = 0;
  int n_start = 0, n_stop = 0, rise_cnt = 0, last_rise = 0, per_meas = 0;
  int slv_mode = 0, slv_idx = 0;
  logic slv_active = 1'b0;
  logic [7:0] slv_tx = '0, slv_rx = '0;
  logic ack_seen = 1'b0, scl_d = 1'b1, sda_d = 1'b1;
  bit finished = 0;

  always #10 clk = ~clk;

  assign scl_bus = ~scl_oe;
  assign sda_bus = ~(sda_oe | slv_low);

  i2c_ctrl_eng dut (
    .clk_i (clk), .rst_ni (rst_n),
    .reg_addr_i (reg_addr), .reg_we_i (reg_we), .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata), .irq_o (irq),
    .scl_i (scl_bus), .scl_oe_o (scl_oe), .sda_i (sda_bus), .sda_oe_o (sda_oe)
  );

  // bus model: 0 ack receiver, 1 transmitter of slv_tx, 2 holds SDA low, 3 nack receiver
  always_comb begin
    slv_low = 1'b0;
    if (slv_active) begin
      case (slv_mode)
        0: slv_low = (slv_idx == 8);
        1: slv_low = (slv_idx < 8) ? ~slv_tx[7 - slv_idx] : 1'b0;
        2: slv_low = 1'b1;
        default: slv_low = 1'b0;
      endcase
    end
  end

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    scl_d <= scl_bus;
    sda_d <= sda_bus;
    if (scl_d && scl_bus && sda_d && !sda_bus) begin
      n_start <= n_start + 1; rise_cnt <= 0; slv_active <= 1'b0;
    end
    if (scl_d && scl_bus && !sda_d && sda_bus) begin
      n_stop <= n_stop + 1; slv_active <= 1'b0;
    end
    if (!scl_d && scl_bus) begin
      if ((rise_cnt % 9) < 8) slv_rx <= {slv_rx[6:0], sda_bus};
      else ack_seen <= sda_bus;
      if ((rise_cnt % 9) == 2) per_meas <= cyc - last_rise;
      last_rise <= cyc;
      rise_cnt  <= rise_cnt + 1;
    end
    if (scl_d && !scl_bus) begin
      slv_active <= 1'b1;
      slv_idx    <= rise_cnt % 9;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_stat(input logic [7:0] mask, input int max);
    logic [7:0] s;
    for (int i = 0; i < max; i++) begin
      rd(2'd1, s);
      if ((s & mask) != 0) break;
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 status", v, 8'h00);
    rd(2'd2, v); chk("R1 data", v, 8'h00);
    chk("R1 lines", {scl_oe, sda_oe}, 2'b00);
    rd(2'd3, v); chk("R13 div reset", v, 8'd4);
  endtask

  task automatic t_ctrl_bits;
    logic [7:0] v;
    int s0;
    wr(2'd0, 8'h5B);
    rd(2'd0, v); chk("R2 low bits read 0", v, 8'h58);
    s0 = n_start;
    wr(2'd0, 8'h20);
    idle(60);
    rd(2'd0, v); chk("R3 mst dropped when disabled", v, 8'h00);
    chk("R3 no start", n_start, s0);
    chk("R3 lines released", {scl_oe, sda_oe}, 2'b00);
  endtask

  task automatic t_write_byte;
    logic [7:0] v;
    int s0;
    slv_mode = 0;
    s0 = n_start;
    wr(2'd0, 8'hF0);
    idle(60);
    chk("R4 start seen", n_start, s0 + 1);
    rd(2'd1, v); chk("R4 busy", v[6], 1'b1);
    chk("R4 scl held", scl_oe, 1'b1);
    chk("R12 no irq yet", irq, 1'b0);
    wr(2'd2, 8'hA5);
    wait_stat(8'h80, 600);
    chk("R5 byte on bus", slv_rx, 8'hA5);
    rd(2'd1, v); chk("R5 ack latched", v[0], 1'b0);
    chk("R7 done set", v[7], 1'b1);
    chk("R7 scl low after byte", scl_oe, 1'b1);
    chk("R12 irq on done", irq, 1'b1);
    chk("R13 period div4", per_meas, 20);
    wr(2'd1, 8'h80);
    rd(2'd1, v); chk("R7 done cleared", v[7], 1'b0);
    chk("R12 irq cleared", irq, 1'b0);
    slv_mode = 3;
    wr(2'd2, 8'h3C);
    wait_stat(8'h80, 600);
    chk("R5 second byte", slv_rx, 8'h3C);
    rd(2'd1, v); chk("R5 nack latched", v[0], 1'b1);
    wr(2'd1, 8'h80);
  endtask

  task automatic t_receive;
    logic [7:0] v;
    wr(2'd0, 8'hE0);
    slv_mode = 1; slv_tx = 8'h96;
    wr(2'd2, 8'h00);
    wait_stat(8'h80, 600);
    rd(2'd2, v); chk("R6 rx byte", v, 8'h96);
    chk("R6 ack driven", ack_seen, 1'b0);
    wr(2'd1, 8'h80);
    wr(2'd0, 8'hE8);
    slv_tx = 8'h5A;
    wr(2'd2, 8'h00);
    wait_stat(8'h80, 600);
    rd(2'd2, v); chk("R6 rx byte 2", v, 8'h5A);
    chk("R6 nack released", ack_seen, 1'b1);
    wr(2'd1, 8'h80);
    slv_mode = 0;
  endtask

  task automatic t_repeat;
    logic [7:0] v;
    int s0, p0;
    s0 = n_start; p0 = n_stop;
    wr(2'd0, 8'hB4);
    idle(60);
    chk("R9 restart seen", n_start, s0 + 1);
    chk("R9 no stop", n_stop, p0);
    rd(2'd1, v); chk("R9 no arb loss", v[4], 1'b0);
    rd(2'd0, v); chk("R2 repeat reads 0", v, 8'hB0);
  endtask

  task automatic t_stop;
    logic [7:0] v;
    int p0;
    p0 = n_stop;
    wr(2'd0, 8'h80);
    idle(60);
    chk("R8 stop seen", n_stop, p0 + 1);
    rd(2'd1, v); chk("R8 busy clear", v[6], 1'b0);
    chk("R8 lines released", {scl_oe, sda_oe}, 2'b00);
  endtask

  task automatic t_rpt_idle;
    logic [7:0] v;
    int s0;
    s0 = n_start;
    wr(2'd0, 8'h84);
    idle(40);
    rd(2'd1, v); chk("R10 arb flag", v[4], 1'b1);
    chk("R10 no start", n_start, s0);
    chk("R12 irq gated", irq, 1'b0);
    wr(2'd0, 8'hC0);
    chk("R12 irq on arb", irq, 1'b1);
    wr(2'd1, 8'h10);
    rd(2'd1, v); chk("R10 arb cleared", v[4], 1'b0);
    chk("R12 irq low", irq, 1'b0);
    wr(2'd0, 8'h80);
  endtask

  task automatic t_arb;
    logic [7:0] v;
    int p0;
    wr(2'd0, 8'hB0);
    idle(60);
    slv_mode = 2;
    p0 = n_stop;
    wr(2'd2, 8'hC0);
    wait_stat(8'h10, 600);
    rd(2'd1, v); chk("R11 arb flag", v[4], 1'b1);
    chk("R11 no done", v[7], 1'b0);
    rd(2'd0, v); chk("R11 mst cleared", v, 8'h90);
    chk("R11 lines released", {scl_oe, sda_oe}, 2'b00);
    chk("R11 no stop", n_stop, p0);
    slv_mode = 0;
    idle(20);
    wr(2'd1, 8'h10);
  endtask

  task automatic t_div;
    wr(2'd3, 8'd7);
    wr(2'd0, 8'hB0);
    idle(80);
    wr(2'd2, 8'h55);
    wait_stat(8'h80, 900);
    chk("R13 period div7", per_meas, 32);
    chk("R5 byte at div7", slv_rx, 8'h55);
    wr(2'd1, 8'h80);
    wr(2'd0, 8'h80);
    idle(80);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_ctrl_bits();
    t_write_byte();
    t_receive();
    t_repeat();
    t_stop();
    t_rpt_idle();
    t_arb();
    t_div();
    finish_run();
  end
endmodule